// File: doc/BRIEF.md
# Reversible 5/3 Integer Lifting Wavelet Engine

This block computes a full dyadic discrete wavelet transform of a vector of eight signed integer samples. It uses the reversible 5/3 integer lifting scheme. In the forward direction it turns samples into wavelet coefficients. In the inverse direction it turns those coefficients back into the exact original samples. No quantization takes place, so every mapping is integer to integer and can be undone without loss.

A single `start` cycle loads the vector and latches the direction. The engine then runs one lifting half-step per clock on an internal register array, updating it in place. Each level first predicts the odd positions (details) and then updates the even positions (approximations). Only the approximation band is decomposed again at the next, coarser level. The inverse direction undoes the levels from coarsest to finest, taking update before predict, with the signs flipped. A one-cycle `done` pulse marks the moment the result on `dout` becomes valid. The result is then held until the next accepted start.

Coefficients stay interleaved in place. Index 0 holds the coarsest approximation, index 4 the coarsest detail, indices 2 and 6 the middle-level details, and the odd indices the finest details.

Top module: `dwt53_top`

## Requirements
- R1: During and directly after a synchronous active-low reset, `done` is 0 and every `dout` element is 0.
- R2: With `inverse`=0 at start, `dout` equals the in-place 5/3 transform over levels of length 8, 4 and 2 (stride 1, 2, 4). Predict makes odd x[j] -= floor((x[j-1]+x[j+1])/2). Update makes even x[j] += floor((x[j-1]+x[j+1]+2)/4). A missing right neighbour mirrors to the left one, and a missing left neighbour mirrors to the right one.
- R3: For forward inputs within the signed DATA_W range, no intermediate value leaves the COEF_W coefficient range.
- R4: Feeding a forward result back with `inverse`=1 returns the original samples exactly.
- R5: `done` is high for exactly one cycle. It rises after the sixth rising edge that follows the edge that sampled `start`.
- R6: A `start` raised while a run is in progress is ignored. The running result and its `done` timing are unchanged.
- R7: While idle with `start` low, `dout` holds its value, whatever `din` does.
- R8: A constant input vector transforms to that constant at index 0 and zero at all other indices.
- R9: The direction is taken from `inverse` only in the cycle that `start` is accepted. Later changes have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load `din` and begin a run when idle |
| inverse | input | 1 | 0 = forward analysis, 1 = inverse synthesis (sampled with start) |
| din | input | N*COEF_W | Eight signed elements, element k at bits [k*COEF_W +: COEF_W] |
| done | output | 1 | One-cycle pulse: `dout` valid |
| dout | output | N*COEF_W | Result array, same packing as `din` |

## Verification
Each run takes exactly six cycles after the edge that accepts `start`. The bench therefore drives `start` on a falling edge and counts rising edges from the sampling edge. It checks at the following falling edge that `done` stays low after edges one to five, is high after edge six, and is low again one edge later. It compares `dout` only after the `done` check. The hold and ignored-start cases are sampled several cycles into idle or mid-run, with `din` and `inverse` changed away from the values that were loaded.

// File: rtl/dwt53_pkg.sv
// Shared types for the 5/3 lifting engine.
// Assumes: none beyond IEEE 1800-2017.
package dwt53_pkg;

    // Which half of a lifting level is applied in a step
    typedef enum logic {
        PH_PREDICT = 1'b0,
        PH_UPDATE  = 1'b1
    } phase_e;

    // Sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dwt53_lift.sv
// Combinational lifting half-step on the whole in-place array.
// For every element and every level a candidate is built at elaboration
// time with fixed neighbour indices (symmetric mirroring at edges); the
// runtime level and phase pick which candidates are applied.
// Assumes N is a power of two, N >= 4, and LEVELS = log2(N).
module dwt53_lift
    import dwt53_pkg::*;
#(
    parameter int N      = 8,
    parameter int LEVELS = 3,
    parameter int CW     = 15,
    parameter int LW     = 2
) (
    input  logic signed [CW-1:0] cur [N],
    input  logic [LW-1:0]        level,
    input  phase_e               phase,
    input  logic                 inv,
    output logic signed [CW-1:0] nxt [N],
    output logic                 ovf
);
    localparam int EW = CW + 3;

    logic signed [EW-1:0] cand [N][LEVELS];
    logic [LEVELS-1:0]    hit  [N];

    genvar gi, gl;
    generate
        for (gi = 0; gi < N; gi++) begin : g_elem
            for (gl = 0; gl < LEVELS; gl++) begin : g_lvl
                localparam int S = 1 << gl;
                localparam int L = N >> gl;
                if ((gi % S) != 0) begin : g_off
                    assign cand[gi][gl] = '0;
                    assign hit[gi][gl]  = 1'b0;
                end else if (((gi / S) % 2) == 1) begin : g_odd
                    localparam int J  = gi / S;
                    localparam int IL = gi - S;
                    localparam int IR = (J + 1 < L) ? gi + S : gi - S;
                    logic signed [EW-1:0] avg;
                    // Predict term: floor of the mean of the even neighbours
                    assign avg = (EW'(cur[IL]) + EW'(cur[IR])) >>> 1;
                    assign cand[gi][gl] = inv ? EW'(cur[gi]) + avg
                                              : EW'(cur[gi]) - avg;
                    assign hit[gi][gl] = (level == LW'(gl)) && (phase == PH_PREDICT);
                end else begin : g_even
                    localparam int J  = gi / S;
                    localparam int IL = (J > 0) ? gi - S : gi + S;
                    localparam int IR = gi + S;
                    logic signed [EW-1:0] upd;
                    // Update term: rounded quarter of the detail neighbours
                    assign upd = (EW'(cur[IL]) + EW'(cur[IR]) + EW'(2)) >>> 2;
                    assign cand[gi][gl] = inv ? EW'(cur[gi]) - upd
                                              : EW'(cur[gi]) + upd;
                    assign hit[gi][gl] = (level == LW'(gl)) && (phase == PH_UPDATE);
                end
            end
        end
    endgenerate

    // Select the active candidate per element and flag range overflow
    always_comb begin
        ovf = 1'b0;
        for (int i = 0; i < N; i++) begin
            nxt[i] = cur[i];
            for (int l = 0; l < LEVELS; l++) begin
                if (hit[i][l]) begin
                    nxt[i] = cand[i][l][CW-1:0];
                    if (cand[i][l] != EW'(signed'(cand[i][l][CW-1:0]))) begin
                        ovf = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dwt53_seq.sv
// Step sequencer: one lifting half-step per cycle, 2*LEVELS steps.
// Forward order: level 0 predict, update, level 1 predict, update, ...
// Inverse order: coarsest level first, update before predict.
// Assumes start is ignored while a run is in progress.
module dwt53_seq
    import dwt53_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int LW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          inverse,
    output logic          load,
    output logic          busy,
    output logic [LW-1:0] level,
    output phase_e        phase,
    output logic          inv_run,
    output logic          done
);
    localparam int STEPS = 2 * LEVELS;
    localparam int SW    = $clog2(STEPS);
    localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

    seq_state_e    state;
    logic [SW-1:0] step;
    logic [SW-1:0] half;

    assign load = (state == ST_IDLE) && start;
    assign busy = (state == ST_RUN);
    assign half = step >> 1;

    // Map step number to level and phase for the latched direction
    always_comb begin
        if (inv_run) begin
            level = LW'(LEVELS - 1) - LW'(half);
            phase = step[0] ? PH_PREDICT : PH_UPDATE;
        end else begin
            level = LW'(half);
            phase = step[0] ? PH_UPDATE : PH_PREDICT;
        end
    end

    // State, step counter, latched direction and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            inv_run <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state   <= ST_RUN;
                step    <= '0;
                inv_run <= inverse;
            end else if (busy) begin
                if (step == LAST) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    step <= step + SW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dwt53_top.sv
// Eight-point multi-level reversible 5/3 lifting transform, in place.
// Loads din on an accepted start, runs 2*LEVELS half-steps, pulses done
// and holds the array on dout until the next accepted start.
// Assumes forward inputs lie in the signed DATA_W range.
module dwt53_top
    import dwt53_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 12,
    parameter int GUARD  = 3,
    parameter int COEF_W = DATA_W + GUARD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                inverse,
    input  logic [N*COEF_W-1:0] din,
    output logic                done,
    output logic [N*COEF_W-1:0] dout
);
    localparam int LEVELS = $clog2(N);
    localparam int LW     = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic signed [COEF_W-1:0] arr [N];
    logic signed [COEF_W-1:0] arr_nxt [N];
    logic          load;
    logic          busy;
    logic [LW-1:0] level;
    phase_e        phase;
    logic          inv_run;
    logic          ovf;

    dwt53_seq #(.LEVELS(LEVELS), .LW(LW)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .inverse (inverse),
        .load    (load),
        .busy    (busy),
        .level   (level),
        .phase   (phase),
        .inv_run (inv_run),
        .done    (done)
    );

    dwt53_lift #(.N(N), .LEVELS(LEVELS), .CW(COEF_W), .LW(LW)) i_lift (
        .cur   (arr),
        .level (level),
        .phase (phase),
        .inv   (inv_run),
        .nxt   (arr_nxt),
        .ovf   (ovf)
    );

    // Working array: load on accepted start, lift in place while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) arr[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < N; i++) arr[i] <= din[i*COEF_W +: COEF_W];
        end else if (busy) begin
            for (int i = 0; i < N; i++) arr[i] <= arr_nxt[i];
        end
    end

    // Pack the array onto the output bus
    always_comb begin
        for (int i = 0; i < N; i++) dout[i*COEF_W +: COEF_W] = arr[i];
    end

endmodule

// File: rtl/dwt53_checker.sv
// Protocol and range properties for dwt53_top, attached with bind.
// Assumes synchronous active-low reset.
module dwt53_checker #(
    parameter int N      = 8,
    parameter int COEF_W = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic                busy,
    input logic                inv_run,
    input logic                ovf,
    input logic [N*COEF_W-1:0] dout
);

    // R1: reset clears done and the result array
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && dout == '0));

    // R5: done lasts a single cycle
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done only ends a run
    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R3: forward runs never leave the coefficient range
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inv_run) |-> !ovf);

    // R7: idle array holds without an accepted start
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dout));

    // R6: a start while busy does not end the run early
    assert_busy_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !done);

endmodule

bind dwt53_top dwt53_checker #(.N(N), .COEF_W(COEF_W)) i_dwt53_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .busy    (busy),
    .inv_run (inv_run),
    .ovf     (ovf),
    .dout    (dout)
);

// File: tb/test_dwt53_top.sv
// Directed bench for dwt53_top: one task per scenario.
module test_dwt53_top;
    localparam int N  = 8;
    localparam int DW = 12;
    localparam int CW = DW + 3;

    typedef int vec_t [N];

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            inverse = 1'b0;
    logic [N*CW-1:0] din = '0;
    logic            done;
    logic [N*CW-1:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    dwt53_top #(.N(N), .DATA_W(DW)) i_dwt53_top (
        .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse),
        .din(din), .done(done), .dout(dout)
    );

    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int elem(input int k);
        return int'($signed(dout[k*CW +: CW]));
    endfunction

    function automatic logic [N*CW-1:0] pack(input vec_t x);
        logic [N*CW-1:0] v;
        for (int k = 0; k < N; k++) v[k*CW +: CW] = CW'(x[k]);
        return v;
    endfunction

    // Reference forward transform built from R2
    function automatic vec_t ref_fwd(input vec_t x);
        vec_t y = x;
        for (int l = 0; l < 3; l++) begin
            int s = 1 << l;
            int n = N >> l;
            for (int j = 1; j < n; j += 2) begin
                int r = (j + 1 < n) ? j + 1 : j - 1;
                y[j*s] -= (y[(j-1)*s] + y[r*s]) >>> 1;
            end
            for (int j = 0; j < n; j += 2) begin
                int lf = (j > 0) ? j - 1 : j + 1;
                y[j*s] += (y[lf*s] + y[(j+1)*s] + 2) >>> 2;
            end
        end
        return y;
    endfunction

    // Start a run and check done timing (R5); returns dout
    task automatic run_op(input vec_t x, input bit inv, output vec_t res);
        @(negedge clk);
        din = pack(x);
        inverse = inv;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c < 6) chk("R5 done early", int'(done), 0);
            else       chk("R5 done due", int'(done), 1);
        end
        for (int k = 0; k < N; k++) res[k] = elem(k);
        @(posedge clk);
        @(negedge clk);
        chk("R5 done single", int'(done), 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done", int'(done), 0);
        for (int k = 0; k < N; k++) chk("R1 dout", elem(k), 0);
        rst_n = 1'b1;
    endtask

    task automatic test_forward(input vec_t x);
        vec_t res;
        vec_t exp = ref_fwd(x);
        run_op(x, 1'b0, res);
        for (int k = 0; k < N; k++) chk("R2 forward", res[k], exp[k]);
    endtask

    task automatic test_roundtrip(input vec_t x);
        vec_t c;
        vec_t back;
        run_op(x, 1'b0, c);
        run_op(c, 1'b1, back);
        for (int k = 0; k < N; k++) chk("R4 roundtrip", back[k], x[k]);
    endtask

    task automatic test_constant(input int v);
        vec_t x;
        vec_t res;
        for (int k = 0; k < N; k++) x[k] = v;
        run_op(x, 1'b0, res);
        for (int k = 0; k < N; k++) chk("R8 constant", res[k], (k == 0) ? v : 0);
    endtask

    task automatic test_busy_start(input vec_t a, input vec_t b);
        vec_t exp = ref_fwd(a);
        @(negedge clk);
        din = pack(a);
        inverse = 1'b0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 2) begin
                start = 1'b1;
                din = pack(b);
                inverse = 1'b1;
            end else if (c == 3) begin
                start = 1'b0;
            end
            if (c < 6) chk("R6 done early", int'(done), 0);
            else       chk("R6 done due", int'(done), 1);
        end
        inverse = 1'b0;
        for (int k = 0; k < N; k++) chk("R6 R9 result", elem(k), exp[k]);
    endtask

    task automatic test_hold(input vec_t x, input vec_t other);
        vec_t res;
        run_op(x, 1'b0, res);
        @(negedge clk);
        din = pack(other);
        inverse = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < N; k++) chk("R7 hold", elem(k), res[k]);
        inverse = 1'b0;
    endtask

    initial begin
        vec_t ramp    = '{0, 100, 200, 300, 400, 500, 600, 700};
        vec_t alt     = '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048};
        vec_t peaks   = '{-2048, 2047, 2047, -2048, -2048, 2047, 2047, -2048};
        vec_t mixed   = '{-7, 13, 5, -1, 99, -300, 42, 3};
        vec_t oddv    = '{1, -1, 3, -3, 0, 2, -5, 5};
        test_reset();
        test_forward(ramp);
        test_forward(alt);
        test_forward(peaks);
        test_forward(mixed);
        test_constant(300);
        test_constant(-77);
        test_roundtrip(mixed);
        test_roundtrip(alt);
        test_roundtrip(peaks);
        test_roundtrip(oddv);
        test_busy_start(mixed, ramp);
        test_hold(oddv, ramp);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule